// File: doc/BRIEF.md
# Bit-Field Pixel Datapath

This block is the data engine of a pixel-oriented processing slice. Each issued operation takes three 32-bit operands. It forms a second ALU source from one of four places: the raw operand, a left-rotated copy of it, a low-bit mask of programmable width, or a bit pattern replicated across the word. It then runs a three-input ALU, and it writes a registered result together with N, C, Z and V flags.

The ALU has four kinds of work. It applies any Boolean function of three inputs, chosen by an 8-entry truth table. It adds or subtracts, either across the full word or as four independent byte lanes. It can add or subtract after the third operand has been ANDed into either source. It can also report the position of a chosen leading or trailing bit feature in operand A.

Every write can be made conditional on the flags left by the previous write. When the condition fails, the operation is dropped: the result and the flags keep their values and no write strobe is raised. Surrounding logic uses the strobe to update a destination register, and multiplication, register storage and decoding stay outside the block.

Top module: `bitfield_pixel_unit`

## Requirements
- R1: When `b_sel`=1, source B is `opnd_b` rotated left by `rot_amt` (0 to 31); an amount of 0 leaves the value unchanged.
- R2: When `b_sel`=2, source B is 2^n − 1 with n = `mask_width`, so width 0 gives zero and width 31 gives 0x7FFFFFFF.
- R3: When `b_sel`=3, source B repeats the low bits of `opnd_b`: `expand_mode` 0 repeats bit 0 32 times, 1 repeats bits [1:0] 16 times, 2 repeats bits [3:0] 8 times, and 3 passes `opnd_b` through. `b_sel`=0 uses `opnd_b` directly.
- R4: When `op_mode`=3, the result is a position in `opnd_a`, with bit 0 as the LSB. `func[1:0]` selects the feature: 0 gives the highest set bit, 1 the lowest set bit, 2 the highest i in 1..31 with a[i]≠a[i−1], and 3 the lowest such i. When nothing matches, the result is 32. Flags are N=0, C=0, V=0 and Z=(result==0).
- R5: When `op_mode`=0, each result bit i is `func[{a[i],b[i],c[i]}]`, using source B. Flags are N=result[31], Z=(result==0), C=0 and V=0.
- R6: When `op_mode`=1 with `split_en`=0, the result is A+B if `func[0]`=0 and A−B if `func[0]`=1, modulo 2^32. C is the carry-out for an add, and for a subtract it is 1 when no borrow occurs. V is signed overflow, N=result[31] and Z=(result==0).
- R7: When `split_en`=1, the arithmetic modes work on four independent 8-bit lanes and no carry or borrow crosses a lane boundary. C and V are taken from the top lane (bits 31:24); N and Z are taken over the whole word.
- R8: When `op_mode`=2, the operation is arithmetic as in R6/R7 on A'=(func[1] ? A&C : A) and B'=(func[2] ? B&C : B), with the flags computed from A' and B'.
- R9: An operation takes effect only if `cond_sel` holds for the stored flags {N,C,Z,V} (`flags`[3:0]). The codes are: 0 always, 1 never, 2 Z, 3 !Z, 4 C, 5 !C, 6 N, 7 !N, 8 V, 9 !V, 10 C&!Z, 11 !C|Z, 12 N==V, 13 N!=V, 14 !Z&(N==V), 15 Z|(N!=V). A failed condition leaves `result` and `flags` unchanged and keeps `wr_en` low.
- R10: After reset, `result`, `flags` and `wr_en` are zero. An operation presented with `op_valid`=1 at a clock edge updates `result` and `flags` and raises `wr_en` for the cycle after that edge. With `op_valid`=0, nothing changes and `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| op_valid | input | 1 | An operation is presented this cycle |
| op_mode | input | 2 | 0 Boolean, 1 arithmetic, 2 masked arithmetic, 3 bit scan |
| func | input | 8 | Truth table, or add/subtract and masking selects, or scan kind |
| split_en | input | 1 | Break arithmetic into four byte lanes |
| b_sel | input | 2 | Source B: 0 operand, 1 rotated, 2 mask, 3 expanded |
| rot_amt | input | 5 | Left-rotate amount |
| mask_width | input | 5 | Number of low ones in the generated mask |
| expand_mode | input | 2 | Replicated field width: 1, 2, 4 bits, or pass |
| cond_sel | input | 4 | Write condition code |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B (rotate/expand source) |
| opnd_c | input | 32 | Operand C (third ALU input, masking operand) |
| result | output | 32 | Registered result |
| flags | output | 4 | Registered {N,C,Z,V} |
| wr_en | output | 1 | Destination write strobe |

## Verification
Every result, every flag and the write strobe is due exactly one clock edge after the operation is presented. The bench drives each operation on a falling edge, lets one rising edge capture it, and compares all three outputs on the following falling edge, before it drives the next operation. Its expected values come from its own arithmetic models of the source selection and the ALU. Condition checks also need a flag model: the bench keeps its own copy of the flags, updates that copy only when it predicts a write, and so tests each condition code against a history it has worked out itself.

// File: rtl/bfp_pkg.sv
`timescale 1ns/1ps
package bfp_pkg;

  typedef enum logic [1:0] {
    OPM_BOOL      = 2'd0,
    OPM_ARITH     = 2'd1,
    OPM_MASKARITH = 2'd2,
    OPM_SCAN      = 2'd3
  } opmode_e;

  typedef enum logic [1:0] {
    BSRC_OPND   = 2'd0,
    BSRC_ROT    = 2'd1,
    BSRC_MASK   = 2'd2,
    BSRC_EXPAND = 2'd3
  } bsrc_e;

  typedef struct packed {
    logic n;
    logic c;
    logic z;
    logic v;
  } flags_t;

  // Evaluate a 4-bit condition code against stored flags
  function automatic logic cond_met(input logic [3:0] code, input flags_t f);
    logic base;
    unique case (code[3:1])
      3'd0: base = 1'b1;
      3'd1: base = f.z;
      3'd2: base = f.c;
      3'd3: base = f.n;
      3'd4: base = f.v;
      3'd5: base = f.c & ~f.z;
      3'd6: base = ~(f.n ^ f.v);
      default: base = ~f.z & ~(f.n ^ f.v);
    endcase
    return code[0] ? ~base : base;
  endfunction

endpackage

// File: rtl/bfp_rotator.sv
`timescale 1ns/1ps
module bfp_rotator #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stg [SW+1];
  assign stg[0] = din;

  // One stage per amount bit: rotate left by 2^k when that bit is set
  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stg[k+1] = amt[k] ? {stg[k][W-1-SH:0], stg[k][W-1:W-SH]} : stg[k];
  end

  assign dout = stg[SW];

endmodule

// File: rtl/bfp_bitscan.sv
`timescale 1ns/1ps
module bfp_bitscan #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0] din,
  input  logic [1:0]   kind,   // [1]: change search, [0]: lowest instead of highest
  output logic [SW:0]  pos
);

  localparam logic [SW:0] NO_HIT = (SW+1)'(W);

  logic [W-1:0] vec;

  always_comb begin
    vec = din;
    if (kind[1]) begin
      vec[0] = 1'b0;
      for (int i = 1; i < W; i++) vec[i] = din[i] ^ din[i-1];
    end
  end

  always_comb begin
    pos = NO_HIT;
    if (!kind[0]) begin
      for (int i = 0; i < W; i++) if (vec[i]) pos = (SW+1)'(i);
    end else begin
      for (int i = W-1; i >= 0; i--) if (vec[i]) pos = (SW+1)'(i);
    end
  end

endmodule

// File: rtl/bfp_alu3.sv
`timescale 1ns/1ps
module bfp_alu3 import bfp_pkg::*; #(
  parameter int W  = 32,
  parameter int LW = 8,
  localparam int LANES = W / LW
) (
  input  opmode_e          mode,
  input  logic [7:0]       func,
  input  logic             split,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [W-1:0]     c,
  input  logic [W-1:0]     scan_val,
  output logic [W-1:0]     res,
  output flags_t           flg
);

  logic [W-1:0]     a_m, b_m, b_x, sum, boolv;
  logic             sub;
  logic [LANES-1:0] lane_cin, lane_cout;
  logic             is_arith;

  assign is_arith = (mode == OPM_ARITH) || (mode == OPM_MASKARITH);
  assign sub      = func[0];

  // Optional masking of the arithmetic sources by the third operand
  always_comb begin
    a_m = a;
    b_m = b;
    if (mode == OPM_MASKARITH) begin
      if (func[1]) a_m = a & c;
      if (func[2]) b_m = b & c;
    end
    b_x = sub ? ~b_m : b_m;
  end

  // Byte-lane adders; split breaks the chain at every lane boundary
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k == 0) begin : g_first
      assign lane_cin[k] = sub;
    end else begin : g_next
      assign lane_cin[k] = split ? sub : lane_cout[k-1];
    end
    assign {lane_cout[k], sum[k*LW +: LW]} =
      {1'b0, a_m[k*LW +: LW]} + {1'b0, b_x[k*LW +: LW]} + {{LW{1'b0}}, lane_cin[k]};
  end

  // Three-input truth-table function, index {a,b,c}
  always_comb begin
    for (int i = 0; i < W; i++) boolv[i] = func[{a[i], b[i], c[i]}];
  end

  always_comb begin
    unique case (mode)
      OPM_BOOL: res = boolv;
      OPM_SCAN: res = scan_val;
      default:  res = sum;
    endcase
    flg.n = (mode == OPM_SCAN) ? 1'b0 : res[W-1];
    flg.z = (res == '0);
    flg.c = is_arith ? lane_cout[LANES-1] : 1'b0;
    flg.v = is_arith ? ((a_m[W-1] == b_x[W-1]) && (sum[W-1] != a_m[W-1])) : 1'b0;
  end

endmodule

// File: rtl/bitfield_pixel_unit.sv
`timescale 1ns/1ps
module bitfield_pixel_unit import bfp_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int SW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_mode,
  input  logic [7:0]        func,
  input  logic              split_en,
  input  logic [1:0]        b_sel,
  input  logic [SW-1:0]     rot_amt,
  input  logic [SW-1:0]     mask_width,
  input  logic [1:0]        expand_mode,
  input  logic [3:0]        cond_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] opnd_c,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flags,
  output logic              wr_en
);

  // Low-bit mask of width n
  function automatic logic [DATA_W-1:0] mk_mask(input logic [SW-1:0] n);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  // Replicate a 1/2/4-bit field across the word, or pass through
  function automatic logic [DATA_W-1:0] mk_expand(input logic [DATA_W-1:0] v,
                                                  input logic [1:0] md);
    logic [DATA_W-1:0] e;
    int fw;
    fw = (md == 2'd0) ? 1 : (md == 2'd1) ? 2 : 4;
    for (int i = 0; i < DATA_W; i++) e[i] = (md == 2'd3) ? v[i] : v[i % fw];
    return e;
  endfunction

  opmode_e           mode;
  logic [DATA_W-1:0] rot_out, mask_out, exp_out, b_eff, alu_res, scan_ext;
  logic [SW:0]       scan_pos;
  flags_t            alu_flg, flags_q;
  logic [DATA_W-1:0] result_q;
  logic              wr_q, take;

  assign mode = opmode_e'(op_mode);

  bfp_rotator #(.W(DATA_W), .SW(SW)) rot_i (
    .din (opnd_b),
    .amt (rot_amt),
    .dout(rot_out)
  );

  assign mask_out = mk_mask(mask_width);
  assign exp_out  = mk_expand(opnd_b, expand_mode);

  always_comb begin
    unique case (bsrc_e'(b_sel))
      BSRC_ROT:    b_eff = rot_out;
      BSRC_MASK:   b_eff = mask_out;
      BSRC_EXPAND: b_eff = exp_out;
      default:     b_eff = opnd_b;
    endcase
  end

  bfp_bitscan #(.W(DATA_W), .SW(SW)) scan_i (
    .din (opnd_a),
    .kind(func[1:0]),
    .pos (scan_pos)
  );

  assign scan_ext = DATA_W'(scan_pos);

  bfp_alu3 #(.W(DATA_W), .LW(LANE_W)) alu_i (
    .mode    (mode),
    .func    (func),
    .split   (split_en),
    .a       (opnd_a),
    .b       (b_eff),
    .c       (opnd_c),
    .scan_val(scan_ext),
    .res     (alu_res),
    .flg     (alu_flg)
  );

  assign take = op_valid && cond_met(cond_sel, flags_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q <= '0;
      flags_q  <= '0;
      wr_q     <= 1'b0;
    end else begin
      wr_q <= take;
      if (take) begin
        result_q <= alu_res;
        flags_q  <= alu_flg;
      end
    end
  end

  assign result = result_q;
  assign flags  = flags_q;
  assign wr_en  = wr_q;

  AST_ROT_ZERO_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_amt == '0) |-> (rot_out == opnd_b)); // R1

  AST_MASK_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mask_out) == int'(mask_width)); // R2

  AST_EXPAND_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    (bsrc_e'(b_sel) == BSRC_EXPAND && expand_mode == 2'd0) |-> ($countones(b_eff) == 0 || $countones(b_eff) == DATA_W)); // R3

  AST_SCAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OPM_SCAN) |-> (alu_res <= DATA_W[DATA_W-1:0])); // R4

  AST_SPLIT_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    (split_en && mode == OPM_ARITH && !func[0] && opnd_a[2*LANE_W-1:LANE_W] == '0 &&
     b_eff[2*LANE_W-1:LANE_W] == '0) |-> (alu_res[2*LANE_W-1:LANE_W] == '0)); // R7

  AST_HOLD_WHEN_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> ($stable(result) && $stable(flags))); // R9

  AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(op_valid)); // R10

endmodule

// File: tb/bitfield_pixel_unit_tb_top.sv
`timescale 1ns/1ps
module bitfield_pixel_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_mode = '0;
  logic [7:0]  func = '0;
  logic        split_en = 1'b0;
  logic [1:0]  b_sel = '0;
  logic [4:0]  rot_amt = '0;
  logic [4:0]  mask_width = '0;
  logic [1:0]  expand_mode = '0;
  logic [3:0]  cond_sel = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
  logic [31:0] result;
  logic [3:0]  flags;
  logic        wr_en;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_res = '0;
  logic [3:0]  m_flg = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  bitfield_pixel_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode), .func(func),
    .split_en(split_en), .b_sel(b_sel), .rot_amt(rot_amt), .mask_width(mask_width),
    .expand_mode(expand_mode), .cond_sel(cond_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .opnd_c(opnd_c), .result(result), .flags(flags), .wr_en(wr_en)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [31:0] ref_beff(input logic [31:0] b, input logic [1:0] sel,
      input logic [4:0] ra, input logic [4:0] mw, input logic [1:0] em);
    logic [63:0] t;
    case (sel)
      2'd1: begin t = {b, b} << ra; return t[63:32]; end
      2'd2: begin t = (64'd1 << mw) - 64'd1; return t[31:0]; end
      2'd3: case (em)
              2'd0: return {32{b[0]}};
              2'd1: return {16{b[1:0]}};
              2'd2: return {8{b[3:0]}};
              default: return b;
            endcase
      default: return b;
    endcase
  endfunction

  function automatic logic [31:0] ref_scan(input logic [31:0] a, input logic [1:0] k);
    case (k)
      2'd0: for (int i = 31; i >= 0; i--) if (a[i]) return i;
      2'd1: for (int i = 0; i < 32; i++) if (a[i]) return i;
      2'd2: for (int i = 31; i >= 1; i--) if (a[i] != a[i-1]) return i;
      default: for (int i = 1; i < 32; i++) if (a[i] != a[i-1]) return i;
    endcase
    return 32;
  endfunction

  // returns {N,C,Z,V,result}
  function automatic logic [35:0] ref_alu(input logic [1:0] md, input logic [7:0] fn,
      input logic sp, input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    logic [31:0] r, am, bm;
    logic [32:0] s;
    logic [8:0]  ls;
    logic cf, vf;
    cf = 1'b0; vf = 1'b0;
    if (md == 2'd0) begin
      for (int i = 0; i < 32; i++) r[i] = (fn >> (a[i]*4 + b[i]*2 + c[i])) & 8'd1;
      return {r[31], 1'b0, r == 0, 1'b0, r};
    end
    if (md == 2'd3) begin
      r = ref_scan(a, fn[1:0]);
      return {1'b0, 1'b0, r == 0, 1'b0, r};
    end
    am = (md == 2'd2 && fn[1]) ? (a & c) : a;
    bm = (md == 2'd2 && fn[2]) ? (b & c) : b;
    if (!sp) begin
      s  = fn[0] ? ({1'b0, am} - {1'b0, bm}) : ({1'b0, am} + {1'b0, bm});
      r  = s[31:0];
      cf = fn[0] ? ~s[32] : s[32];
    end else begin
      for (int k = 0; k < 4; k++) begin
        ls = fn[0] ? ({1'b0, am[k*8 +: 8]} - {1'b0, bm[k*8 +: 8]})
                   : ({1'b0, am[k*8 +: 8]} + {1'b0, bm[k*8 +: 8]});
        r[k*8 +: 8] = ls[7:0];
        if (k == 3) cf = fn[0] ? ~ls[8] : ls[8];
      end
    end
    if (fn[0]) vf = (am[31] != bm[31]) && (r[31] != am[31]);
    else       vf = (am[31] == bm[31]) && (r[31] != am[31]);
    return {r[31], cf, r == 0, vf, r};
  endfunction

  function automatic bit ref_cond(input logic [3:0] cd, input logic [3:0] f);
    bit n, c, z, v;
    {n, c, z, v} = f;
    case (cd)
      0: return 1;   1: return 0;
      2: return z;   3: return !z;
      4: return c;   5: return !c;
      6: return n;   7: return !n;
      8: return v;   9: return !v;
      10: return c && !z;  11: return !c || z;
      12: return n == v;   13: return n != v;
      14: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge with inputs set; checks one edge later.
  task automatic exec(input string tag);
    logic [35:0] e;
    bit ok;
    ok = op_valid && ref_cond(cond_sel, m_flg);
    e  = ref_alu(op_mode, func, split_en, opnd_a,
                 ref_beff(opnd_b, b_sel, rot_amt, mask_width, expand_mode), opnd_c);
    @(negedge clk);
    if (ok) begin m_res = e[31:0]; m_flg = e[35:32]; end
    chk({tag, " result"}, result, m_res);
    chk({tag, " flags"}, {28'd0, flags}, {28'd0, m_flg});
    chk({tag, " wr_en"}, {31'd0, wr_en}, {31'd0, ok});
  endtask

  task automatic set_op(input logic [1:0] md, input logic [7:0] fn, input logic sp,
                        input logic [1:0] bs);
    op_valid = 1'b1; op_mode = md; func = fn; split_en = sp; b_sel = bs; cond_sel = 4'd0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset result", result, 32'd0);
    chk("R10 reset flags", {28'd0, flags}, 32'd0);
    chk("R10 reset wr_en", {31'd0, wr_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: rotate sweep, passed through with truth table 0xCC (result = B)
    set_op(2'd0, 8'hCC, 1'b0, 2'd1);
    for (int v = 0; v < 4; v++) begin
      opnd_b = (v == 0) ? 32'h8000_0001 : rnd();
      for (int r = 0; r < 32; r++) begin rot_amt = r[4:0]; exec("R1 rotate"); end
    end

    // R2: mask width sweep
    set_op(2'd0, 8'hCC, 1'b0, 2'd2);
    for (int n = 0; n < 32; n++) begin mask_width = n[4:0]; exec("R2 mask"); end

    // R3: expand modes and direct B
    set_op(2'd0, 8'hCC, 1'b0, 2'd3);
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 16; p++) begin
        expand_mode = m[1:0]; opnd_b = {rnd()} & 32'hFFFF_FFF0 | p; exec("R3 expand");
      end
    set_op(2'd0, 8'hCC, 1'b0, 2'd0);
    opnd_b = 32'hDEAD_BEEF; exec("R3 direct");

    // R4: bit scan, all kinds
    for (int k = 0; k < 4; k++) begin
      set_op(2'd3, {6'd0, k[1:0]}, 1'b0, 2'd0);
      opnd_a = 32'd0;          exec("R4 scan zero");
      opnd_a = 32'hFFFF_FFFF;  exec("R4 scan ones");
      for (int i = 0; i < 32; i++) begin
        opnd_a = 32'd1 << i;            exec("R4 scan single");
        opnd_a = ~((32'd1 << i) - 1);   exec("R4 scan edge");
      end
      for (int j = 0; j < 16; j++) begin opnd_a = rnd(); exec("R4 scan random"); end
    end

    // R5: every truth table on varied vectors
    for (int f = 0; f < 256; f++)
      for (int j = 0; j < 3; j++) begin
        set_op(2'd0, f[7:0], 1'b0, 2'd0);
        opnd_a = rnd(); opnd_b = rnd(); opnd_c = rnd(); exec("R5 boolean");
      end

    // R6: full-width add/sub, corners and random
    set_op(2'd1, 8'h00, 1'b0, 2'd0);
    opnd_a = 32'h7FFF_FFFF; opnd_b = 32'd1; exec("R6 add overflow");
    opnd_a = 32'hFFFF_FFFF; opnd_b = 32'd1; exec("R6 add carry zero");
    set_op(2'd1, 8'h01, 1'b0, 2'd0);
    opnd_a = 32'd0; opnd_b = 32'd1;           exec("R6 sub borrow");
    opnd_a = 32'h8000_0000; opnd_b = 32'd1;   exec("R6 sub overflow");
    opnd_a = 32'h55; opnd_b = 32'h55;         exec("R6 sub equal");
    for (int j = 0; j < 200; j++) begin
      set_op(2'd1, {7'd0, j[0]}, 1'b0, 2'd0);
      opnd_a = rnd(); opnd_b = rnd(); exec("R6 arith");
    end

    // R7: split lanes
    set_op(2'd1, 8'h00, 1'b1, 2'd0);
    opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h0101_0101; exec("R7 lane carry stop");
    opnd_a = 32'h7F00_00FF; opnd_b = 32'h0100_0001; exec("R7 lane overflow");
    set_op(2'd1, 8'h01, 1'b1, 2'd0);
    opnd_a = 32'h0000_0000; opnd_b = 32'h0101_0101; exec("R7 lane borrow stop");
    for (int j = 0; j < 200; j++) begin
      set_op(2'd1, {7'd0, j[0]}, 1'b1, 2'd0);
      opnd_a = rnd(); opnd_b = rnd(); exec("R7 split arith");
    end

    // R8: masked arithmetic, all mask/sub combos, both widths
    for (int f = 0; f < 8; f++)
      for (int j = 0; j < 40; j++) begin
        set_op(2'd2, {5'd0, f[2:0]}, j[0], 2'd0);
        opnd_a = rnd(); opnd_b = rnd(); opnd_c = rnd(); exec("R8 masked");
      end

    // R9: every condition code after several flag-setting setups
    for (int s = 0; s < 6; s++)
      for (int cd = 0; cd < 16; cd++) begin
        set_op(2'd1, {7'd0, s[0]}, 1'b0, 2'd0);
        case (s)
          0: begin opnd_a = 32'hFFFF_FFFF; opnd_b = 32'd1; end
          1: begin opnd_a = 32'h8000_0000; opnd_b = 32'd1; end
          2: begin opnd_a = 32'h7FFF_FFFF; opnd_b = 32'd1; end
          3: begin opnd_a = 32'd0;         opnd_b = 32'd1; end
          default: begin opnd_a = rnd();   opnd_b = rnd(); end
        endcase
        exec("R9 setup");
        set_op(2'd0, 8'hF0, 1'b0, 2'd0);
        cond_sel = cd[3:0]; opnd_a = rnd(); exec("R9 conditional");
      end

    // R10: op_valid low changes nothing
    set_op(2'd0, 8'hF0, 1'b0, 2'd0);
    opnd_a = 32'h1357_9BDF; exec("R10 valid write");
    op_valid = 1'b0; opnd_a = 32'h0; exec("R10 idle hold");
    opnd_a = 32'hFFFF_0000; exec("R10 idle hold again");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule